// File: doc/BRIEF.md
# Load Store Alignment Unit

This unit sits between a 32-bit integer pipeline and a byte-addressed data memory port. For each access it forms the effective address by adding the sign-extended 16-bit displacement to the base register value. It then checks that the address sits on the natural boundary of the access size. A misaligned access raises a load or store address-error flag and is never sent to memory.

For stores, the unit drives a little-endian byte-lane write-enable mask and copies the store data onto every lane the access may land on. For loads, it keeps a small record of the access that is in flight. In the cycle the memory returns its word, the unit picks the addressed lanes, widens them to 32 bits with sign or zero extension, and writes the result to the destination register.

Top module: `lsu_align_unit`

## Requirements
- R1: When `req_valid_i` is high and the access is aligned, `mem_req_o` is high and `mem_addr_o` equals `base_i` plus `imm_i` sign-extended to 32 bits, with the sum taken modulo 2^32.
- R2: The size code `req_size_i` is 00 for a byte, 01 for a halfword and 10 for a word, and code 11 behaves as a word. `mem_we_o` is high for a request with `req_store_i`=1 and low for a load.
- R3: A halfword whose address bit 0 is 1 is misaligned. A word whose address bits 1:0 are not 00 is misaligned. A byte is never misaligned. With `req_valid_i` high, a misaligned load raises `exc_load_o` and a misaligned store raises `exc_store_o`, in the same cycle.
- R4: During an exception, `mem_req_o` is 0 and `mem_be_o` is 0000. No register write follows, so `rf_we_o` stays 0 in the next cycle even if `mem_rvalid_i` is high.
- R5: Bit i of `mem_be_o` enables byte lane i, which holds data bits 8i+7:8i (little-endian). A byte access enables only lane addr[1:0]. A halfword enables lanes 1:0 when addr[1]=0 and lanes 3:2 when addr[1]=1. A word enables all four lanes. Loads drive the same mask.
- R6: For a byte store, `mem_wdata_o` holds `wdata_i[7:0]` in all four lanes. For a halfword store it holds `wdata_i[15:0]` in both halves. For a word store it equals `wdata_i`.
- R7: For an accepted load, `rf_we_o` is high in the cycle `mem_rvalid_i` is high, which is the cycle after the request. In that cycle `rf_waddr_o` equals the load's `rt_i`, and `rf_wdata_o` is built from the lanes selected by the load's address as in R5.
- R8: With `req_unsigned_i`=1, a sub-word load is zero-extended to 32 bits; with 0 it is sign-extended. A word load ignores `req_unsigned_i`.
- R9: With `req_valid_i` low, `mem_req_o`, `exc_load_o` and `exc_store_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access presented this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_unsigned_i | input | 1 | Zero-extend a sub-word load |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store data from register rt |
| rt_i | input | 5 | Destination register of a load |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Effective byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 32 | Extended load result |
| exc_load_o | output | 1 | Load address error |
| exc_store_o | output | 1 | Store address error |

## Verification
The bench sweeps every size code and every low address offset, for loads and stores, with both extension modes. It uses negative displacements and bases whose low bits carry into the high bits. A wrong alignment rule would leave a misaligned access going to memory, or would trap an access that is legal. A wrong lane mapping would write or read the wrong byte or the wrong half. Swapped extension would fill the upper bits with copies of the sign bit when zeros are wanted, or the other way round. A missing suppression would leave a nonzero byte mask, or a register write, after a trapped access.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  size_e            size_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             misalign_o
);
  localparam int EXT_W = XLEN - IMM_W;

  assign addr_o = base_i + {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_o[0];
      default: misalign_o = |addr_o[1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  size_e                      size_i,
  input  logic [$clog2(XLEN/8)-1:0]  off_i,
  input  logic [XLEN-1:0]            wdata_i,
  output logic [XLEN/8-1:0]          be_o,
  output logic [XLEN-1:0]            wdata_o
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(i);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          be_o[i]         = (off_i == LANE_ID);
          wdata_o[8*i+:8] = wdata_i[7:0];
        end
        SZ_HALF: begin
          be_o[i]         = (off_i[OFF_W-1:1] == LANE_ID[OFF_W-1:1]);
          wdata_o[8*i+:8] = wdata_i[8*(i%2)+:8];
        end
        default: begin
          be_o[i]         = 1'b1;
          wdata_o[8*i+:8] = wdata_i[8*i+:8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  size_e                      size_i,
  input  logic                       unsigned_i,
  input  logic [$clog2(XLEN/8)-1:0]  off_i,
  input  logic [XLEN-1:0]            rdata_i,
  output logic [XLEN-1:0]            result_o
);
  localparam int OFF_W = $clog2(XLEN / 8);

  logic [XLEN-1:0] shifted;
  logic            fill;

  assign shifted = rdata_i >> {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        fill     = ~unsigned_i & shifted[7];
        result_o = {{(XLEN-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill     = ~unsigned_i & shifted[15];
        result_o = {{(XLEN-16){fill}}, shifted[15:0]};
      end
      default: begin
        fill     = 1'b0;
        result_o = shifted;
      end
    endcase
  end

  // R8: a zero-extended byte has no bits above lane 0
  always_comb begin
    if (size_i == SZ_BYTE && unsigned_i)
      p_zext_byte_r8: assert (result_o[XLEN-1:8] == '0);
  end

  localparam int UNUSED_OFF_W = OFF_W;
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [REG_AW-1:0] rt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN/8-1:0] mem_be_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              exc_load_o,
  output logic              exc_store_o
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  size_e             size;
  logic              misalign;
  logic [LANES-1:0]  lane_be;
  logic              load_go;

  logic              pend_q;
  size_e             pend_size_q;
  logic              pend_uns_q;
  logic [OFF_W-1:0]  pend_off_q;
  logic [REG_AW-1:0] pend_rt_q;

  assign size = size_e'(req_size_i);

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base_i     (base_i),
    .imm_i      (imm_i),
    .size_i     (size),
    .addr_o     (mem_addr_o),
    .misalign_o (misalign)
  );

  lsu_store_lane #(.XLEN(XLEN)) u_store (
    .size_i  (size),
    .off_i   (mem_addr_o[OFF_W-1:0]),
    .wdata_i (wdata_i),
    .be_o    (lane_be),
    .wdata_o (mem_wdata_o)
  );

  assign exc_load_o  = req_valid_i & ~req_store_i & misalign;
  assign exc_store_o = req_valid_i &  req_store_i & misalign;
  assign mem_req_o   = req_valid_i & ~misalign;
  assign mem_we_o    = req_store_i;
  assign mem_be_o    = mem_req_o ? lane_be : '0;
  assign load_go     = mem_req_o & ~req_store_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_size_q <= SZ_WORD;
      pend_uns_q  <= 1'b0;
      pend_off_q  <= '0;
      pend_rt_q   <= '0;
    end else if (load_go) begin
      pend_q      <= 1'b1;
      pend_size_q <= size;
      pend_uns_q  <= req_unsigned_i;
      pend_off_q  <= mem_addr_o[OFF_W-1:0];
      pend_rt_q   <= rt_i;
    end else if (mem_rvalid_i) begin
      pend_q <= 1'b0;
    end
  end

  lsu_load_extract #(.XLEN(XLEN)) u_load (
    .size_i     (pend_size_q),
    .unsigned_i (pend_uns_q),
    .off_i      (pend_off_q),
    .rdata_i    (mem_rdata_i),
    .result_o   (rf_wdata_o)
  );

  assign rf_we_o    = pend_q & mem_rvalid_i;
  assign rf_waddr_o = pend_rt_q;

  // R4: a trapped access never reaches memory
  p_exc_blocks_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_load_o | exc_store_o) |-> (!mem_req_o && mem_be_o == '0));

  // R4: no register write in the cycle after a trapped load
  p_exc_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_load_o && !mem_req_o) |=> !rf_we_o);

  // R3: issued halfwords and words are naturally aligned
  p_issued_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((size == SZ_HALF) ? !mem_addr_o[0] :
                   (size == SZ_BYTE) ? 1'b1 : (mem_addr_o[1:0] == 2'b00)));

  // R5: lane count follows access size
  p_lane_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) ==
                   ((size == SZ_BYTE) ? 1 : (size == SZ_HALF) ? 2 : LANES)));

  // R9: idle cycles issue nothing and trap nothing
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(mem_req_o | exc_load_o | exc_store_o));
endmodule

// File: tb/lsu_align_unit_test.sv
module lsu_align_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_unsigned_i = 1'b0;
  logic [1:0]  req_size_i = 2'b00;
  logic [31:0] base_i = '0, wdata_i = '0, mem_rdata_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  rt_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        mem_req_o, mem_we_o, rf_we_o, exc_load_o, exc_store_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rf_wdata_o;
  logic [3:0]  mem_be_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lsu_align_unit uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                        input logic [31:0] base, input logic [15:0] imm,
                        input logic [31:0] wd, input logic [4:0] rt,
                        input logic [31:0] rd);
    logic [31:0] ea, exp_wd, exp_res, sh;
    logic [3:0]  exp_be;
    bit          bad;
    ea = base + {{16{imm[15]}}, imm};
    bad = (sz == 2'b01) ? ea[0] : (sz == 2'b00) ? 1'b0 : (ea[1:0] != 2'b00);
    case (sz)
      2'b00: begin exp_be = 4'b0001 << ea[1:0]; exp_wd = {4{wd[7:0]}}; end
      2'b01: begin exp_be = ea[1] ? 4'b1100 : 4'b0011; exp_wd = {2{wd[15:0]}}; end
      default: begin exp_be = 4'b1111; exp_wd = wd; end
    endcase
    sh = rd >> (8 * ea[1:0]);
    case (sz)
      2'b00: exp_res = uns ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
      2'b01: exp_res = uns ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      default: exp_res = rd;
    endcase
    @(negedge clk_i);
    mem_rvalid_i = 0;
    req_valid_i = 1; req_store_i = st; req_size_i = sz; req_unsigned_i = uns;
    base_i = base; imm_i = imm; wdata_i = wd; rt_i = rt;
    #1;
    chk("R3 exc_load", {31'd0, exc_load_o}, {31'd0, bad & !st});
    chk("R3 exc_store", {31'd0, exc_store_o}, {31'd0, bad & st});
    if (bad) begin
      chk("R4 req suppressed", {31'd0, mem_req_o}, 0);
      chk("R4 be zero", {28'd0, mem_be_o}, 0);
    end else begin
      chk("R1 req", {31'd0, mem_req_o}, 1);
      chk("R1 addr", mem_addr_o, ea);
      chk("R2 we", {31'd0, mem_we_o}, {31'd0, st});
      chk("R5 be", {28'd0, mem_be_o}, {28'd0, exp_be});
      if (st) chk("R6 wdata", mem_wdata_o, exp_wd);
    end
    @(negedge clk_i);
    req_valid_i = 0;
    mem_rvalid_i = 1; mem_rdata_i = rd;
    #1;
    chk("R9 idle req", {31'd0, mem_req_o | exc_load_o | exc_store_o}, 0);
    if (!st && !bad) begin
      chk("R7 rf_we", {31'd0, rf_we_o}, 1);
      chk("R7 waddr", {27'd0, rf_waddr_o}, {27'd0, rt});
      chk(sz == 2'b10 ? "R8 word data" : "R8 extend", rf_wdata_o, exp_res);
    end else begin
      chk("R4 no rf write", {31'd0, rf_we_o}, 0);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R9 reset req", {31'd0, mem_req_o}, 0);
    chk("R7 reset rf_we", {31'd0, rf_we_o}, 0);
    #10 rst_ni = 1;
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int u = 0; u < 2; u++) begin
            access(st[0], sz[1:0], u[0], 32'h0000_1000 + off, 16'h0010,
                   32'hA1B2_C3D4, 5'(off + 4 * sz + 1), 32'h80F1_7F92);
            access(st[0], sz[1:0], u[0], 32'h0000_2003, 16'(off - 3 - 8),
                   32'h5E6F_8091, 5'(31 - off), 32'h7F80_FF01);
          end
    // carry from low bits into upper address bits with a negative offset
    access(1'b0, 2'b10, 1'b0, 32'hFFFF_FFFE, 16'h0002, 32'h0, 5'd9, 32'hDEAD_BEEF);
    access(1'b1, 2'b01, 1'b0, 32'h0001_0000, 16'hFFFE, 32'h1234_5678, 5'd3, 32'h0);
    access(1'b0, 2'b00, 1'b0, 32'h0000_0000, 16'h8003, 32'h0, 5'd7, 32'h8000_0000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule